// File: doc/BRIEF.md
# Transmit Command Word Parser

This block sits between a host write port and a transmit byte FIFO. The host writes a stream of 32-bit words. Each transmit buffer in that stream starts with two command words, A and B, and its data words follow. The parser decodes word A to get five things: the payload length, a byte start offset, the first-segment and last-segment markers, an end-alignment selection and a completion request. It then consumes exactly the data words that belong to the buffer. Bytes in front of the start offset are dropped, and so are bytes past the payload length. The alignment padding words the host appended are also dropped. Each data word that still carries payload leaves the block one clock later, as a 32-bit word with a byte strobe, first/last packet markers and the packet tag.

A packet may span several buffers, and word B must stay the same for all of them. The block remembers word B from the first segment of the packet. It raises a one-cycle transmit-error pulse if a later buffer of the same packet brings a different word B. A segment-marker sequence that breaks packet framing also raises the error pulse and returns the parser to its idle state.

The parser has four states:
- **CMD_A**: idle; the next accepted word is command A.
- **CMD_B**: waits for command B.
- **DATA**: forwards payload words.
- **PAD**: discards alignment padding.

The transitions are:
- CMD_A→CMD_B on any accepted word.
- CMD_B→CMD_A on a framing error or an empty buffer.
- CMD_B→DATA otherwise.
- DATA→PAD after the last data word when padding is due.
- DATA→CMD_A after the last data word when no padding is due.
- PAD→CMD_A after the last padding word.

Top module: `txcmd_parser`

## Requirements
- R1: After reset, out_valid, out_first, out_last, done and txe are 0, no packet is open, and the next accepted word is decoded as command A.
- R2: The fields of command A are:
  - bits 10:0: payload length in bytes.
  - bits 20:16: start offset, 0 to 31.
  - bit 13: first segment (FS).
  - bit 12: last segment (LS).
  - bits 25:24: alignment.
  - bit 31: completion request.

  Data bytes are little-endian: lane k is in_data[8k+7:8k] and is flagged by out_be[k]. Lanes before the start offset are never flagged, and out_data is zero on unflagged lanes.
- R3: A buffer consumes ceil((offset+length)/4) data words. Exactly `length` payload bytes are flagged, starting at byte position `offset` and counting positions from 0 at lane 0 of the first data word. Data words with no payload byte produce no out_valid.
- R4: Alignment code 00 adds no padding, 01 rounds the data-word count up to a multiple of 4 words, and 10 rounds it up to a multiple of 8 words. The reserved code 11 acts as 00. Padding words are consumed and produce no output.
- R5: out_first is 1 only on the output word that holds the first payload byte of a buffer whose FS bit is set.
- R6: out_last is 1 only on the output word that holds the final payload byte of a buffer whose LS bit is set.
- R7: When the completion bit is set, done pulses for one cycle, in the cycle after the buffer's last consumed word (data or padding). When the completion bit is clear, done stays 0.
- R8: If a buffer with FS clear brings a command B that differs from the one stored at the packet's first segment, txe pulses in the cycle after that command B, and the buffer's data is still forwarded.
- R9: Command B with FS set while a packet is open, or with FS clear while no packet is open, pulses txe in the next cycle, closes the packet and forwards nothing. The next accepted word is then decoded as command A.
- R10: out_tag carries bits 31:16 of the current buffer's command B on every output word.
- R11: Cycles with in_valid low change no state, and out_valid only follows an accepted data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is presented on in_data this cycle |
| in_data | input | 32 | Command or data word from the host |
| out_valid | output | 1 | An output word with at least one payload byte |
| out_data | output | 32 | Payload word, unflagged lanes zero |
| out_be | output | 4 | Per-lane byte valid strobe |
| out_first | output | 1 | Word holds the first byte of a packet |
| out_last | output | 1 | Word holds the final byte of a packet |
| out_tag | output | 16 | Packet tag from command B |
| done | output | 1 | Buffer completion pulse |
| txe | output | 1 | Transmit error pulse |

## Verification
The internal state that matters here is the word counter and the packet-open flag. A counter that is off by one shows up one cycle after the affected word: a strobe on the wrong lanes, a missing or misplaced first/last marker, or a padding word leaking onto out_valid. After that the whole following buffer decodes as garbage, and the scoreboard reports it at the next output word. A wrong packet-open flag shows up as a wrong txe value in the cycle right after the next command B. The bench therefore samples txe at that cycle after every command B and checks done one cycle after each buffer's final word.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
    localparam int TXP_W   = 32;
    localparam int LANES   = TXP_W / 8;
    localparam int LEN_W   = 11;
    localparam int OFS_W   = 5;
    localparam int TAG_W   = 16;
    localparam int CNT_W   = LEN_W - 1;

    localparam int IOC_BIT = 31;
    localparam int AL_HI   = 25;
    localparam int AL_LO   = 24;
    localparam int OFS_HI  = 20;
    localparam int OFS_LO  = 16;
    localparam int FS_BIT  = 13;
    localparam int LS_BIT  = 12;
    localparam int TAG_LO  = 16;

    typedef enum logic [1:0] {
        ST_CMD_A = 2'd0,
        ST_CMD_B = 2'd1,
        ST_DATA  = 2'd2,
        ST_PAD   = 2'd3
    } txp_state_e;

    typedef struct packed {
        logic             ioc;
        logic [1:0]       align;
        logic [OFS_W-1:0] ofs;
        logic             fs;
        logic             ls;
        logic [LEN_W-1:0] len;
    } txp_cmd_t;
endpackage

// File: rtl/txcmd_decode.sv
module txcmd_decode
    import txcmd_pkg::*;
(
    input  logic [TXP_W-1:0] word_a,
    output txp_cmd_t         cmd,
    output logic [CNT_W-1:0] data_dw,
    output logic [CNT_W-1:0] pad_dw
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] span;
    logic [CNT_W-1:0] amask;
    logic             unused_rsvd;

    assign unused_rsvd = ^{word_a[30:26], word_a[23:21], word_a[15:14], word_a[11]};

    always_comb begin
        cmd.ioc   = word_a[IOC_BIT];
        cmd.align = word_a[AL_HI:AL_LO];
        cmd.ofs   = word_a[OFS_HI:OFS_LO];
        cmd.fs    = word_a[FS_BIT];
        cmd.ls    = word_a[LS_BIT];
        cmd.len   = word_a[LEN_W-1:0];
        // words spanned by offset plus payload, rounded up to whole words
        span      = SUM_W'(cmd.ofs) + SUM_W'(cmd.len) + SUM_W'(3);
        data_dw   = CNT_W'(span >> 2);
        unique case (cmd.align)
            2'b01:   amask = CNT_W'(3);
            2'b10:   amask = CNT_W'(7);
            default: amask = '0;
        endcase
        // words missing to the next alignment boundary
        pad_dw = (~data_dw + CNT_W'(1)) & amask;
    end
endmodule

// File: rtl/txcmd_lane_mask.sv
module txcmd_lane_mask
    import txcmd_pkg::*;
#(
    parameter int LANE_N = LANES
) (
    input  logic [CNT_W-1:0] word_idx,
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] len,
    output logic [LANE_N-1:0] be
);
    localparam int POS_W = CNT_W + $clog2(LANE_N) + 1;

    logic [POS_W-1:0] lo;
    logic [POS_W-1:0] hi;
    logic [POS_W-1:0] base;

    assign lo   = POS_W'(ofs);
    assign hi   = POS_W'(ofs) + POS_W'(len);
    assign base = POS_W'(word_idx) * POS_W'(LANE_N);

    for (genvar k = 0; k < LANE_N; k++) begin : g_lane
        logic [POS_W-1:0] pos;
        assign pos   = base + POS_W'(k);
        assign be[k] = (pos >= lo) && (pos < hi);
    end
endmodule

// File: rtl/txcmd_parser.sv
module txcmd_parser
    import txcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TXP_W-1:0] in_data,
    output logic             out_valid,
    output logic [TXP_W-1:0] out_data,
    output logic [LANES-1:0] out_be,
    output logic             out_first,
    output logic             out_last,
    output logic [TAG_W-1:0] out_tag,
    output logic             done,
    output logic             txe
);
    localparam int POS_W = LEN_W + 1;

    txp_state_e       state_q, state_d;
    txp_cmd_t         cmd_dec, cmd_q;
    logic [CNT_W-1:0] dw_dec, pad_dec;
    logic [CNT_W-1:0] data_dw_q, pad_dw_q, cnt_q;
    logic             pkt_open_q;
    logic [TXP_W-1:0] pkt_b_q;
    logic [TAG_W-1:0] tag_q;
    logic [LANES-1:0] lane_be;
    logic [TXP_W-1:0] lane_bits;

    logic take_a, take_b, take_d, take_p;
    logic frame_err, b_mismatch, last_data, last_pad, empty_buf, buf_end;
    logic [POS_W-1:0] end_pos;
    logic [CNT_W-1:0] first_idx, last_idx;
    logic             unused_align;

    txcmd_decode u_decode (
        .word_a  (in_data),
        .cmd     (cmd_dec),
        .data_dw (dw_dec),
        .pad_dw  (pad_dec)
    );

    txcmd_lane_mask #(.LANE_N(LANES)) u_lanes (
        .word_idx (cnt_q),
        .ofs      (cmd_q.ofs),
        .len      (cmd_q.len),
        .be       (lane_be)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bytemask
        assign lane_bits[8*k +: 8] = {8{lane_be[k]}};
    end

    assign unused_align = ^cmd_q.align;

    assign take_a = in_valid && (state_q == ST_CMD_A);
    assign take_b = in_valid && (state_q == ST_CMD_B);
    assign take_d = in_valid && (state_q == ST_DATA);
    assign take_p = in_valid && (state_q == ST_PAD);

    // FS must open a packet exactly when none is open
    assign frame_err  = (cmd_q.fs == pkt_open_q);
    assign b_mismatch = !cmd_q.fs && pkt_open_q && (in_data != pkt_b_q);
    assign last_data  = (cnt_q == data_dw_q - CNT_W'(1));
    assign last_pad   = (cnt_q == pad_dw_q - CNT_W'(1));
    assign empty_buf  = (data_dw_q == '0);
    assign buf_end    = (take_b && !frame_err && empty_buf)
                      || (take_d && last_data && (pad_dw_q == '0))
                      || (take_p && last_pad);

    assign end_pos   = POS_W'(cmd_q.ofs) + POS_W'(cmd_q.len) - POS_W'(1);
    assign first_idx = CNT_W'(cmd_q.ofs >> 2);
    assign last_idx  = CNT_W'(end_pos >> 2);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD_A: if (in_valid) state_d = ST_CMD_B;
            ST_CMD_B: if (in_valid) state_d = (frame_err || empty_buf) ? ST_CMD_A : ST_DATA;
            ST_DATA:  if (in_valid && last_data)
                          state_d = (pad_dw_q != '0) ? ST_PAD : ST_CMD_A;
            ST_PAD:   if (in_valid && last_pad) state_d = ST_CMD_A;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CMD_A;
        else        state_q <= state_d;
    end

    // buffer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            data_dw_q  <= '0;
            pad_dw_q   <= '0;
            cnt_q      <= '0;
            pkt_open_q <= 1'b0;
            pkt_b_q    <= '0;
            tag_q      <= '0;
        end else begin
            if (take_a) begin
                cmd_q     <= cmd_dec;
                data_dw_q <= dw_dec;
                pad_dw_q  <= pad_dec;
            end
            if (take_b) begin
                cnt_q <= '0;
                tag_q <= in_data[TXP_W-1:TAG_LO];
                if (frame_err) begin
                    pkt_open_q <= 1'b0;
                end else if (cmd_q.fs) begin
                    pkt_open_q <= 1'b1;
                    pkt_b_q    <= in_data;
                end
            end
            if (take_d) cnt_q <= last_data ? '0 : cnt_q + CNT_W'(1);
            if (take_p) cnt_q <= cnt_q + CNT_W'(1);
            if (buf_end && cmd_q.ls) pkt_open_q <= 1'b0;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_be    <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_tag   <= '0;
            done      <= 1'b0;
            txe       <= 1'b0;
        end else begin
            out_valid <= take_d && (lane_be != '0);
            out_data  <= in_data & lane_bits;
            out_be    <= take_d ? lane_be : '0;
            out_first <= take_d && (lane_be != '0) && cmd_q.fs && (cnt_q == first_idx);
            out_last  <= take_d && (lane_be != '0) && cmd_q.ls && (cnt_q == last_idx);
            out_tag   <= tag_q;
            done      <= buf_end && cmd_q.ioc;
            txe       <= take_b && (frame_err || b_mismatch);
        end
    end
endmodule

// File: rtl/txcmd_parser_chk.sv
module txcmd_parser_chk
    import txcmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input txp_state_e       state_q,
    input logic             out_valid,
    input logic [LANES-1:0] out_be,
    input logic             out_first,
    input logic             out_last,
    input logic             done,
    input logic             txe
);
    p_be_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be != '0));

    p_first_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_txe_after_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txe |-> $past(in_valid && (state_q == ST_CMD_B)));

    p_out_from_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && (state_q == ST_DATA)));

    p_pad_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_PAD) |-> !out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_CMD_A) |-> !(out_valid || txe));
endmodule

bind txcmd_parser txcmd_parser_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .state_q   (state_q),
    .out_valid (out_valid),
    .out_be    (out_be),
    .out_first (out_first),
    .out_last  (out_last),
    .done      (done),
    .txe       (txe)
);

// File: tb/txcmd_parser_tb.sv
`timescale 1ns/1ps
module txcmd_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_first, out_last;
    logic [15:0] out_tag;
    logic        done, txe;

    int checks = 0;
    int fails  = 0;
    int seed   = 5;
    bit finished = 0;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  be;
        logic        f;
        logic        l;
        logic [15:0] tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    txcmd_parser u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_be(out_be),
        .out_first(out_first), .out_last(out_last), .out_tag(out_tag),
        .done(done), .txe(txe)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11 unexpected out_valid", {32'h0, out_data}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(out_be == e.be, "R2/R3 byte strobe", 64'(out_be), 64'(e.be));
                chk(out_data == e.d, "R2 data lanes", 64'(out_data), 64'(e.d));
                chk(out_first == e.f, "R5 first flag", 64'(out_first), 64'(e.f));
                chk(out_last == e.l, "R6 last flag", 64'(out_last), 64'(e.l));
                chk(out_tag == e.tag, "R10 tag", 64'(out_tag), 64'(e.tag));
            end
        end
    end

    task automatic put_word(input logic [31:0] w, input bit gap);
        if (gap) begin
            in_valid = 1'b0;
            in_data  = 32'hA5A5_3C3C;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hFFFF_FFFF;
    endtask

    function automatic logic [7:0] bval(input int p);
        return 8'((seed + p) & 255);
    endfunction

    // drive one buffer; framing errors send only the two command words
    task automatic send_buf(input bit ioc, input logic [1:0] al, input int ofs, input int len,
                            input bit fs, input bit ls, input logic [31:0] bw,
                            input bit exp_txe, input bit frame_bad, input bit gap);
        logic [31:0] wa;
        int dw, aw, tot;
        wa = '0;
        wa[31] = ioc; wa[25:24] = al; wa[20:16] = 5'(ofs);
        wa[13] = fs; wa[12] = ls; wa[10:0] = 11'(len);
        dw = (ofs + len + 3) / 4;
        aw = (al == 2'b01) ? 4 : (al == 2'b10) ? 8 : 1;
        tot = ((dw + aw - 1) / aw) * aw;
        if (!frame_bad) begin
            for (int i = 0; i < dw; i++) begin
                exp_t e;
                e.be = '0; e.d = '0;
                for (int k = 0; k < 4; k++) begin
                    int p;
                    p = i * 4 + k;
                    if (p >= ofs && p < ofs + len) begin
                        e.be[k] = 1'b1;
                        e.d[8*k +: 8] = bval(p);
                    end
                end
                e.f = fs && (i == ofs / 4);
                e.l = ls && (i == (ofs + len - 1) / 4);
                e.tag = bw[31:16];
                if (e.be != 0) exp_q.push_back(e);
            end
        end
        put_word(wa, gap);
        put_word(bw, gap);
        chk(txe == exp_txe, frame_bad ? "R9 framing txe" : "R8 txe after B", 64'(txe), 64'(exp_txe));
        if (frame_bad) begin
            chk(out_valid == 1'b0, "R9 no output", 64'(out_valid), 64'h0);
        end else begin
            for (int i = 0; i < tot; i++) begin
                logic [31:0] w;
                for (int k = 0; k < 4; k++) w[8*k +: 8] = bval(i * 4 + k);
                put_word(w, gap && (i % 2 == 1));
                if (i >= dw) chk(out_valid == 1'b0, "R4 padding silent", 64'(out_valid), 64'h0);
            end
            chk(done == ioc, "R7 done pulse", 64'(done), 64'(ioc));
            @(negedge clk);
            chk(done == 1'b0, "R7 done single", 64'(done), 64'h0);
        end
        seed += 37;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(out_valid == 0 && done == 0 && txe == 0 && out_first == 0 && out_last == 0,
            "R1 reset outputs", {59'h0, out_valid, done, txe, out_first, out_last}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R1 idle after reset", 64'(out_valid), 64'h0);

        // R2 R3 R7: aligned single buffer
        send_buf(1, 2'b00, 0, 8, 1, 1, 32'h1111_0000, 0, 0, 0);
        // R2 R4: offset 3, 16-byte alignment -> 2 data + 2 pad
        send_buf(1, 2'b01, 3, 5, 1, 1, 32'h2222_0001, 0, 0, 0);
        // R4 R7: 32-byte alignment, no completion request -> 5 data + 3 pad
        send_buf(0, 2'b10, 7, 13, 1, 1, 32'h3333_0002, 0, 0, 0);
        // R4 reserved alignment acts as none
        send_buf(1, 2'b11, 1, 2, 1, 1, 32'h4444_0003, 0, 0, 0);
        // R5 R6 one byte at offset 31: first and last on same word
        send_buf(1, 2'b00, 31, 1, 1, 1, 32'h5555_0004, 0, 0, 0);
        // R5 R6 R10 R11 three-segment packet with stalls
        send_buf(0, 2'b01, 2, 9, 1, 0, 32'h6666_0005, 0, 0, 1);
        send_buf(0, 2'b00, 0, 6, 0, 0, 32'h6666_0005, 0, 0, 1);
        send_buf(1, 2'b10, 5, 10, 0, 1, 32'h6666_0005, 0, 0, 1);
        // R8 mismatch in middle segment: data still forwarded
        send_buf(0, 2'b00, 0, 4, 1, 0, 32'h7777_0006, 0, 0, 0);
        send_buf(0, 2'b00, 1, 4, 0, 0, 32'h7778_0006, 1, 0, 0);
        send_buf(1, 2'b00, 0, 3, 0, 1, 32'h7777_0006, 0, 0, 0);
        // R9 framing errors and resync
        send_buf(1, 2'b00, 0, 4, 0, 1, 32'h8888_0007, 1, 1, 0);
        send_buf(0, 2'b00, 0, 4, 1, 0, 32'h9999_0008, 0, 0, 0);
        send_buf(1, 2'b00, 0, 4, 1, 1, 32'h9999_0009, 1, 1, 0);
        send_buf(1, 2'b00, 0, 4, 0, 1, 32'h9999_000A, 1, 1, 0);
        send_buf(1, 2'b00, 2, 7, 1, 1, 32'hAAAA_000B, 0, 0, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all expected words seen", 64'(exp_q.size()), 64'h0);
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule